// File: doc/BRIEF.md
# Dual-Strobe Decimal Up/Down Digit

This block is one decimal digit (0 to 9) that lives on a system clock. It has two strobe inputs instead of a direction pin. A rising edge on the up strobe moves the digit forward, and a rising edge on the down strobe moves it back. The block finds these edges itself by sampling both strobes on the system clock. A synchronous master clear forces the digit to zero. An active-low load copies a 4-bit preset value into the digit.

The block has two active-low terminal outputs:

- The carry-out goes low while the digit rests at 9 and the up strobe is low.
- The borrow-out goes low while the digit rests at 0 and the down strobe is low.

Each output rises again together with the strobe edge that makes the digit wrap. Because of this, a multi-digit counter is built by feeding one digit's carry-out into the next digit's up strobe and its borrow-out into the next digit's down strobe. If a code from 10 to 15 reaches the register, for example through the preset, the next count returns the digit to the legal range.

Top module: `bcd_dual_strobe_digit`

## Requirements
- R1: After the system reset `rst_n` is released, the digit reads 0, and carry-out and borrow-out are both high while the strobes are high.
- R2: When `clr_i` is high at a clock edge, the digit becomes 0 on that edge. This overrides the load and both strobes.
- R3: When `clr_i` is low and `load_n_i` is low at a clock edge, the digit takes the value of `preset_i`, whatever the strobes are doing.
- R4: An up step happens when `up_i` is sampled 0 and then 1 while `dn_i` is high and did not rise in the same sample. An up step adds one to the digit, and 9 wraps to 0.
- R5: A down step happens when `dn_i` is sampled 0 and then 1 while `up_i` is high and did not rise in the same sample. A down step subtracts one from the digit, and 0 wraps to 9.
- R6: The digit holds its value in three cases:
  - both strobes rise in the same sample;
  - one strobe rises while the other is low;
  - no strobe rises.
- R7: `carry_n_o` is low exactly when the digit is 9 and `up_i` is low. It is combinational from those two signals.
- R8: `borrow_n_o` is low exactly when the digit is 0 and `dn_i` is low. It is combinational from those two signals.
- R9: From an illegal code (10 to 15), an up step gives 0 and a down step gives 9.
- R10: Two digits can be chained by wiring the low digit's `carry_n_o` to the high digit's `up_i` and the low digit's `borrow_n_o` to the high digit's `dn_i`. The pair then counts as one two-digit decimal number. The low digit's wrap and the high digit's step land on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_i | input | 1 | Synchronous master clear, active high |
| load_n_i | input | 1 | Synchronous parallel load, active low |
| preset_i | input | 4 | Value copied into the digit on a load |
| up_i | input | 1 | Count-up strobe; rising edge steps forward |
| dn_i | input | 1 | Count-down strobe; rising edge steps back |
| count_o | output | 4 | Current digit value |
| carry_n_o | output | 1 | Active-low terminal count going up |
| borrow_n_o | output | 1 | Active-low terminal count going down |

## Verification
The bench targets the wraps in both directions and the illegal codes 10 to 15 loaded through the preset.

- A digit with a plain binary step would leave 9 for 10 or 15.
- A digit with a plain binary step would stay stuck above 9.

The bench also covers three other cases:

- Both strobes rising together, and one strobe rising while the other is low. A design that checks only the rising strobe would count in these cases when it should hold.
- Clear and load asserted together. A design with the wrong priority loads the preset instead of clearing.
- A chained two-digit pair. Terminal outputs that were registered, or that were not gated by the strobe level, would give the high digit no edge or an edge one cycle late.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_INC   = 3'd1,
        ACT_DEC   = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_CLEAR = 3'd4
    } bcdc_act_e;

    localparam int unsigned STROBE_UP = 0;
    localparam int unsigned STROBE_DN = 1;
    localparam int unsigned STROBE_N  = 2;

endpackage

// File: rtl/bcdc_edge.sv
module bcdc_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_d, prev_q;

        always_comb begin
            prev_d = lvl_i[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= prev_d;
        end

        assign rise_o[g] = lvl_i[g] & ~prev_q;
    end
endmodule

// File: rtl/bcdc_arbiter.sv
module bcdc_arbiter
    import bcdc_pkg::*;
(
    input  logic                clr_i,
    input  logic                load_n_i,
    input  logic [STROBE_N-1:0] lvl_i,
    input  logic [STROBE_N-1:0] rise_i,
    output bcdc_act_e           act_o
);
    logic up_ok, dn_ok;

    always_comb begin
        up_ok = rise_i[STROBE_UP] & lvl_i[STROBE_DN] & ~rise_i[STROBE_DN];
        dn_ok = rise_i[STROBE_DN] & lvl_i[STROBE_UP] & ~rise_i[STROBE_UP];
        if (clr_i)         act_o = ACT_CLEAR;
        else if (!load_n_i) act_o = ACT_LOAD;
        else if (up_ok)    act_o = ACT_INC;
        else if (dn_ok)    act_o = ACT_DEC;
        else               act_o = ACT_HOLD;
    end
endmodule

// File: rtl/bcdc_step.sv
module bcdc_step
    import bcdc_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] preset_i,
    input  bcdc_act_e    act_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    always_comb begin
        unique case (act_i)
            ACT_CLEAR: cnt_o = '0;
            ACT_LOAD:  cnt_o = preset_i;
            ACT_INC:   cnt_o = (cnt_i >= TOP) ? '0 : cnt_i + 1'b1;
            ACT_DEC:   cnt_o = (cnt_i == '0 || cnt_i > TOP) ? TOP : cnt_i - 1'b1;
            default:   cnt_o = cnt_i;
        endcase
    end
endmodule

// File: rtl/bcdc_tc.sv
module bcdc_tc #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic         up_i,
    input  logic         dn_i,
    output logic         carry_n_o,
    output logic         borrow_n_o
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    always_comb begin
        carry_n_o  = ~((cnt_i == TOP) & ~up_i);
        borrow_n_o = ~((cnt_i == '0)  & ~dn_i);
    end
endmodule

// File: rtl/bcd_dual_strobe_digit.sv
module bcd_dual_strobe_digit
    import bcdc_pkg::*;
#(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_n_i,
    input  logic [W-1:0] preset_i,
    input  logic         up_i,
    input  logic         dn_i,
    output logic [W-1:0] count_o,
    output logic         carry_n_o,
    output logic         borrow_n_o
);
    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;
    logic [STROBE_N-1:0] lvl, rise;
    bcdc_act_e act;
    logic [W-1:0] cnt_nxt;

    assign lvl[STROBE_UP] = up_i;
    assign lvl[STROBE_DN] = dn_i;

    bcdc_edge #(.N(STROBE_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise)
    );

    bcdc_arbiter u_arb (
        .clr_i(clr_i), .load_n_i(load_n_i), .lvl_i(lvl), .rise_i(rise), .act_o(act)
    );

    bcdc_step #(.MODULUS(MODULUS), .W(W)) u_step (
        .cnt_i(state_q.cnt), .preset_i(preset_i), .act_i(act), .cnt_o(cnt_nxt)
    );

    bcdc_tc #(.MODULUS(MODULUS), .W(W)) u_tc (
        .cnt_i(state_q.cnt), .up_i(up_i), .dn_i(dn_i),
        .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count_o = state_q.cnt;

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == '0);

    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !load_n_i) |=> count_o == $past(preset_i));

    a_r6_both_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && load_n_i && rise[STROBE_UP] && rise[STROBE_DN]) |=> $stable(count_o));

    a_r7_carry_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == TOP && !up_i));

    a_r8_borrow_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == '0 && !dn_i));

    a_r9_recover_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o > TOP && (act == ACT_INC || act == ACT_DEC)) |=> count_o <= TOP);
endmodule

// File: tb/bcd_dual_strobe_digit_tb_top.sv
module bcd_dual_strobe_digit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, ld_n = 1'b1, up = 1'b1, dn = 1'b1;
    logic [3:0] pre = 4'd0;
    logic [3:0] cnt_lo, cnt_hi, pre_hi;
    logic c_lo, b_lo, c_hi, b_hi;

    int total = 0, bad = 0;
    int m_lo = 0, m_hi = 0;
    bit pu = 1, pd = 1, hpu = 1, hpd = 1;
    string pend = "R1";

    always #10 clk = ~clk;

    assign pre_hi = 4'd0;

    bcd_dual_strobe_digit dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_n_i(ld_n), .preset_i(pre),
        .up_i(up), .dn_i(dn), .count_o(cnt_lo), .carry_n_o(c_lo), .borrow_n_o(b_lo)
    );

    bcd_dual_strobe_digit dut_hi (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_n_i(1'b1), .preset_i(pre_hi),
        .up_i(c_lo), .dn_i(b_lo), .count_o(cnt_hi), .carry_n_o(c_hi), .borrow_n_o(b_hi)
    );

    function automatic int f_next(int c, bit cl, bit ln, int p, bit u, bit d, bit ppu, bit ppd);
        bit ur = u & ~ppu;
        bit dr = d & ~ppd;
        if (cl) return 0;
        if (!ln) return p;
        if (ur && d && !dr) return (c >= 9) ? 0 : c + 1;
        if (dr && u && !ur) return (c == 0 || c > 9) ? 9 : c - 1;
        return c;
    endfunction

    function automatic bit f_carry(int c, bit u);
        return !(c == 9 && !u);
    endfunction

    function automatic bit f_borrow(int c, bit d);
        return !(c == 0 && !d);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(bit cl, bit ln, int p, bit u, bit d);
        bit ur, dr, ec, eb;
        @(negedge clk);
        check(pend, int'(cnt_lo), m_lo);
        check("R10 high digit", int'(cnt_hi), m_hi);
        clr = cl; ld_n = ln; pre = 4'(p); up = u; dn = d;
        #1;
        ec = f_carry(m_lo, u);
        eb = f_borrow(m_lo, d);
        check("R7 carry", int'(c_lo), int'(ec));
        check("R8 borrow", int'(b_lo), int'(eb));
        check("R10 high carry", int'(c_hi), int'(f_carry(m_hi, ec)));
        check("R10 high borrow", int'(b_hi), int'(f_borrow(m_hi, eb)));
        ur = u & ~pu;
        dr = d & ~pd;
        if (cl) pend = "R2";
        else if (!ln) pend = "R3";
        else if (m_lo > 9 && ((ur && d && !dr) || (dr && u && !ur))) pend = "R9";
        else if (ur && d && !dr) pend = "R4";
        else if (dr && u && !ur) pend = "R5";
        else pend = "R6";
        m_hi = f_next(m_hi, cl, 1'b1, 0, ec, eb, hpu, hpd);
        m_lo = f_next(m_lo, cl, ln, p, u, d, pu, pd);
        pu = u; pd = d; hpu = ec; hpd = eb;
    endtask

    task automatic pulse_up(int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 1, 0, 0, 1);
            cyc(0, 1, 0, 1, 1);
        end
    endtask

    task automatic pulse_dn(int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 1, 0, 1, 0);
            cyc(0, 1, 0, 1, 1);
        end
    endtask

    initial begin
        #4_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        check("R1 count", int'(cnt_lo), 0);
        check("R1 carry", int'(c_lo), 1);
        check("R1 borrow", int'(b_lo), 1);
        // R4 and R10: count up through wraps
        pulse_up(23);
        // R5: count down through the zero wrap
        pulse_dn(30);
        // R3: load while strobes move
        cyc(0, 0, 7, 0, 0);
        cyc(0, 0, 7, 1, 1);
        // R2: clear beats load
        cyc(1, 0, 5, 1, 1);
        // R6: both rise together
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 0, 1, 1);
        // R6: up rises while down low
        cyc(0, 1, 0, 0, 0);
        cyc(0, 1, 0, 1, 0);
        cyc(0, 1, 0, 1, 1);
        // R9: illegal codes, both directions
        for (int k = 10; k < 16; k++) begin
            cyc(0, 0, k, 1, 1);
            pulse_up(1);
            cyc(0, 0, k, 1, 1);
            pulse_dn(1);
        end
        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit cl = ($urandom % 40) == 0;
            bit ln = ($urandom % 20) != 0;
            int p  = int'($urandom % 16);
            bit u  = ($urandom % 3) != 0;
            bit d  = ($urandom % 3) != 0;
            cyc(cl, ln, p, u, d);
        end
        cyc(0, 1, 0, 1, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule